// File: doc/BRIEF.md
# Event Routing and Queue Writer

This block sits between an interrupt source stage and a per-thread presenter. The source stage hands it a source number. The block then walks two small internal tables. The first is a per-source assignment entry: a mask flag, the index of a target descriptor, and an event data word. The second is a target descriptor: a valid flag, the target CPU, the priority, and the state of one circular event queue (base address, log2 size, current index and a generation toggle). When the source is unmasked and the descriptor is valid, the block writes one queue entry. It then notifies the presenter with the CPU and priority so that the presenter can raise the matching pending bit.

Queue entries carry no head or tail pointers. Every entry stores the generation toggle in its most significant bit, above the event data. A consumer detects fresh entries by their toggle polarity. The toggle inverts each time the producer index wraps. Both tables are plain register arrays, loaded through two write ports for configuration. Notifications are accepted with a valid/ready handshake and are processed one at a time through a fixed three-stage lookup, so the source stage never loses an event.

Top module: `evt_route_qwr`

## Requirements
- R1: After reset, `ntf_ready` is 1, `qw_valid`, `pr_valid` and `err_cnt` are 0, every source is masked and every descriptor is invalid.
- R2: A notify from a masked source produces no queue write and no presenter notify. It does not change `err_cnt` and does not advance any queue index.
- R3: The written entry `qw_data` is `{toggle, event_data}`: bit DATA_W holds the descriptor's toggle and bits DATA_W-1:0 hold the source's configured event data.
- R4: `qw_addr` equals the descriptor base plus the descriptor's current index, with one entry per address unit.
- R5: Each queue write advances that descriptor's index by one. A write at index 2^log2size - 1 wraps the index to 0 and inverts the toggle.
- R6: A configuration write to a descriptor sets its index to 0 and its toggle to 1.
- R7: On the cycle after a queue write, `pr_valid` is 1 with that write's CPU and priority on `pr_cpu` and `pr_prio`. `pr_valid` is 0 on every other cycle.
- R8: A notify is taken on a clock edge where `ntf_valid` and `ntf_ready` are both 1. `ntf_ready` stays 0 for the next two edges. For a valid target, `qw_valid` is high for exactly the one cycle after the second of those edges. A notify held during backpressure is taken later and is not lost.
- R9: A notify that reaches an invalid descriptor is discarded with no write or notify. `err_cnt` increments by one and saturates at its maximum value.
- R10: Each descriptor keeps its own index and toggle. Writes through one descriptor leave the queue position of another unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notify request from the source stage |
| ntf_src | input | SRC_W | Source number of the notify |
| ntf_ready | output | 1 | Block can take a notify this cycle |
| asg_we | input | 1 | Write strobe for an assignment entry |
| asg_idx | input | SRC_W | Source whose assignment entry is written |
| asg_mask | input | 1 | Mask flag to store (1 = drop events) |
| asg_desc | input | DESC_W | Descriptor index to store |
| asg_data | input | DATA_W | Event data word to store |
| dsc_we | input | 1 | Write strobe for a descriptor |
| dsc_idx | input | DESC_W | Descriptor being written |
| dsc_valid | input | 1 | Valid flag to store |
| dsc_cpu | input | CPU_W | Target CPU to store |
| dsc_prio | input | PRIO_W | Priority to store |
| dsc_base | input | ADDR_W | Queue base address to store |
| dsc_lg | input | LOGSZ_W | Log2 of the queue entry count |
| qw_valid | output | 1 | Queue entry write strobe |
| qw_addr | output | ADDR_W | Queue entry address |
| qw_data | output | DATA_W+1 | Toggle bit over the event data |
| pr_valid | output | 1 | Presenter notify strobe |
| pr_cpu | output | CPU_W | CPU for the presenter |
| pr_prio | output | PRIO_W | Priority for the presenter |
| err_cnt | output | ERR_W | Saturating count of invalid-descriptor discards |

## Verification
The hardest state to reach from the ports is the toggle inversion at a wrap. It only becomes visible when the same descriptor has taken a full queue's worth of writes and is then written again. The configuration gives descriptors small queues of four and two entries, and the vector walk interleaves sources on both of them. Each queue therefore wraps partway through the walk, and the following entries show the inverted toggle at the restarted base address. A separate stretch drives 300 notifies into an invalid descriptor to reach the saturation point of the error counter.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASG  = 2'd1,
        ST_DSC  = 2'd2
    } rt_state_e;
endpackage

// File: rtl/evt_asg_table.sv
module evt_asg_table #(
    parameter int SRC_W  = 4,
    parameter int DESC_W = 3,
    parameter int DATA_W = 16,
    localparam int N     = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SRC_W-1:0]  widx,
    input  logic              wmask,
    input  logic [DESC_W-1:0] wdesc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_W-1:0]  ridx,
    output logic              rmask,
    output logic [DESC_W-1:0] rdesc,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              mask;
        logic [DESC_W-1:0] desc;
        logic [DATA_W-1:0] data;
    } asg_ent_t;

    asg_ent_t tab_q [N];
    asg_ent_t tab_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) tab_d[i] = tab_q[i];
        if (we) tab_d[widx] = '{mask: wmask, desc: wdesc, data: wdata};
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) tab_q[i] <= '{mask: 1'b1, desc: '0, data: '0};
            else        tab_q[i] <= tab_d[i];
        end
    end

    assign rmask = tab_q[ridx].mask;
    assign rdesc = tab_q[ridx].desc;
    assign rdata = tab_q[ridx].data;
endmodule

// File: rtl/evt_dsc_table.sv
module evt_dsc_table #(
    parameter int DESC_W  = 3,
    parameter int CPU_W   = 3,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 16,
    parameter int LOGSZ_W = 3,
    localparam int IDX_W  = (1 << LOGSZ_W) - 1,
    localparam int N      = 1 << DESC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DESC_W-1:0]  cfg_idx,
    input  logic               cfg_valid,
    input  logic [CPU_W-1:0]   cfg_cpu,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LOGSZ_W-1:0] cfg_lg,
    input  logic               adv_en,
    input  logic [DESC_W-1:0]  ridx,
    output logic               r_valid,
    output logic [CPU_W-1:0]   r_cpu,
    output logic [PRIO_W-1:0]  r_prio,
    output logic [ADDR_W-1:0]  r_addr,
    output logic               r_tgl
);
    typedef struct packed {
        logic               vld;
        logic [CPU_W-1:0]   cpu;
        logic [PRIO_W-1:0]  prio;
        logic [ADDR_W-1:0]  base;
        logic [LOGSZ_W-1:0] lg;
        logic [IDX_W-1:0]   idx;
        logic               tgl;
    } dsc_ent_t;

    dsc_ent_t tab_q [N];
    dsc_ent_t tab_d [N];

    function automatic logic [IDX_W:0] span_of(input logic [LOGSZ_W-1:0] lg);
        return (IDX_W+1)'(1) << lg;
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) tab_d[i] = tab_q[i];
        if (adv_en) begin
            if ({1'b0, tab_q[ridx].idx} + 1'b1 == span_of(tab_q[ridx].lg)) begin
                tab_d[ridx].idx = '0;
                tab_d[ridx].tgl = ~tab_q[ridx].tgl;
            end else begin
                tab_d[ridx].idx = tab_q[ridx].idx + 1'b1;
            end
        end
        // A configuration write wins over a same-cycle advance.
        if (cfg_we) begin
            tab_d[cfg_idx] = '{vld: cfg_valid, cpu: cfg_cpu, prio: cfg_prio,
                               base: cfg_base, lg: cfg_lg, idx: '0, tgl: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) tab_q[i] <= '{vld: 1'b0, cpu: '0, prio: '0, base: '0,
                                      lg: '0, idx: '0, tgl: 1'b1};
            else        tab_q[i] <= tab_d[i];
        end
    end

    assign r_valid = tab_q[ridx].vld;
    assign r_cpu   = tab_q[ridx].cpu;
    assign r_prio  = tab_q[ridx].prio;
    assign r_addr  = tab_q[ridx].base + ADDR_W'(tab_q[ridx].idx);
    assign r_tgl   = tab_q[ridx].tgl;

    // R5: the index of the selected queue never leaves its ring
    p_idx_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tab_q[ridx].idx} < span_of(tab_q[ridx].lg)));

    // R5: advancing from the last slot returns to slot 0 with the toggle inverted
    p_wrap_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !cfg_we &&
         ({1'b0, tab_q[ridx].idx} + 1'b1 == span_of(tab_q[ridx].lg)))
        |=> (tab_q[$past(ridx)].idx == '0 &&
             tab_q[$past(ridx)].tgl != $past(tab_q[ridx].tgl)));

    // R6: a configured descriptor restarts at slot 0 with toggle 1
    p_cfg_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (tab_q[$past(cfg_idx)].idx == '0 && tab_q[$past(cfg_idx)].tgl));
endmodule

// File: rtl/evt_route_ctl.sv
module evt_route_ctl
    import evt_route_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int DESC_W = 3,
    parameter int DATA_W = 16,
    parameter int CPU_W  = 3,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 16,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ntf_valid,
    input  logic [SRC_W-1:0]  ntf_src,
    output logic              ntf_ready,
    output logic [SRC_W-1:0]  asg_ridx,
    input  logic              asg_rmask,
    input  logic [DESC_W-1:0] asg_rdesc,
    input  logic [DATA_W-1:0] asg_rdata,
    output logic [DESC_W-1:0] dsc_ridx,
    output logic              adv_en,
    input  logic              dsc_rvalid,
    input  logic [CPU_W-1:0]  dsc_rcpu,
    input  logic [PRIO_W-1:0] dsc_rprio,
    input  logic [ADDR_W-1:0] dsc_raddr,
    input  logic              dsc_rtgl,
    output logic              qw_valid,
    output logic [ADDR_W-1:0] qw_addr,
    output logic [DATA_W:0]   qw_data,
    output logic              pr_valid,
    output logic [CPU_W-1:0]  pr_cpu,
    output logic [PRIO_W-1:0] pr_prio,
    output logic [ERR_W-1:0]  err_cnt
);
    typedef struct packed {
        rt_state_e         st;
        logic [SRC_W-1:0]  src;
        logic [DESC_W-1:0] desc;
        logic [DATA_W-1:0] data;
        logic              qv;
        logic [ADDR_W-1:0] qa;
        logic [DATA_W:0]   qd;
        logic [CPU_W-1:0]  cpu;
        logic [PRIO_W-1:0] prio;
        logic              pv;
        logic [CPU_W-1:0]  pcpu;
        logic [PRIO_W-1:0] pprio;
        logic [ERR_W-1:0]  err;
    } ctl_t;

    ctl_t s_q, s_d;
    logic adv_d;

    always_comb begin
        s_d       = s_q;
        adv_d     = 1'b0;
        s_d.qv    = 1'b0;
        s_d.pv    = s_q.qv;
        s_d.pcpu  = s_q.cpu;
        s_d.pprio = s_q.prio;
        case (s_q.st)
            ST_IDLE: if (ntf_valid) begin
                s_d.src = ntf_src;
                s_d.st  = ST_ASG;
            end
            ST_ASG: begin
                s_d.desc = asg_rdesc;
                s_d.data = asg_rdata;
                s_d.st   = asg_rmask ? ST_IDLE : ST_DSC;
            end
            ST_DSC: begin
                s_d.st = ST_IDLE;
                if (dsc_rvalid) begin
                    s_d.qv   = 1'b1;
                    s_d.qa   = dsc_raddr;
                    s_d.qd   = {dsc_rtgl, s_q.data};
                    s_d.cpu  = dsc_rcpu;
                    s_d.prio = dsc_rprio;
                    adv_d    = 1'b1;
                end else if (s_q.err != '1) begin
                    s_d.err = s_q.err + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ntf_ready = (s_q.st == ST_IDLE);
    assign asg_ridx  = s_q.src;
    assign dsc_ridx  = s_q.desc;
    assign adv_en    = adv_d;
    assign qw_valid  = s_q.qv;
    assign qw_addr   = s_q.qa;
    assign qw_data   = s_q.qd;
    assign pr_valid  = s_q.pv;
    assign pr_cpu    = s_q.pcpu;
    assign pr_prio   = s_q.pprio;
    assign err_cnt   = s_q.err;

    // R2: a masked lookup ends the job with no write two edges later
    p_mask_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ASG && asg_rmask) |=> ##1 !qw_valid);

    // R9: the error count moves by at most one per cycle
    p_err_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));
endmodule

// File: rtl/evt_route_qwr.sv
module evt_route_qwr #(
    parameter int SRC_W   = 4,
    parameter int DESC_W  = 3,
    parameter int DATA_W  = 16,
    parameter int CPU_W   = 3,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 16,
    parameter int LOGSZ_W = 3,
    parameter int ERR_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ntf_valid,
    input  logic [SRC_W-1:0]   ntf_src,
    output logic               ntf_ready,
    input  logic               asg_we,
    input  logic [SRC_W-1:0]   asg_idx,
    input  logic               asg_mask,
    input  logic [DESC_W-1:0]  asg_desc,
    input  logic [DATA_W-1:0]  asg_data,
    input  logic               dsc_we,
    input  logic [DESC_W-1:0]  dsc_idx,
    input  logic               dsc_valid,
    input  logic [CPU_W-1:0]   dsc_cpu,
    input  logic [PRIO_W-1:0]  dsc_prio,
    input  logic [ADDR_W-1:0]  dsc_base,
    input  logic [LOGSZ_W-1:0] dsc_lg,
    output logic               qw_valid,
    output logic [ADDR_W-1:0]  qw_addr,
    output logic [DATA_W:0]    qw_data,
    output logic               pr_valid,
    output logic [CPU_W-1:0]   pr_cpu,
    output logic [PRIO_W-1:0]  pr_prio,
    output logic [ERR_W-1:0]   err_cnt
);
    logic [SRC_W-1:0]  a_ridx;
    logic              a_mask;
    logic [DESC_W-1:0] a_desc;
    logic [DATA_W-1:0] a_data;
    logic [DESC_W-1:0] d_ridx;
    logic              d_adv, d_valid, d_tgl;
    logic [CPU_W-1:0]  d_cpu;
    logic [PRIO_W-1:0] d_prio;
    logic [ADDR_W-1:0] d_addr;

    evt_asg_table #(.SRC_W(SRC_W), .DESC_W(DESC_W), .DATA_W(DATA_W)) u_asg (
        .clk(clk), .rst_n(rst_n),
        .we(asg_we), .widx(asg_idx), .wmask(asg_mask), .wdesc(asg_desc), .wdata(asg_data),
        .ridx(a_ridx), .rmask(a_mask), .rdesc(a_desc), .rdata(a_data)
    );

    evt_dsc_table #(.DESC_W(DESC_W), .CPU_W(CPU_W), .PRIO_W(PRIO_W),
                    .ADDR_W(ADDR_W), .LOGSZ_W(LOGSZ_W)) u_dsc (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(dsc_we), .cfg_idx(dsc_idx), .cfg_valid(dsc_valid), .cfg_cpu(dsc_cpu),
        .cfg_prio(dsc_prio), .cfg_base(dsc_base), .cfg_lg(dsc_lg),
        .adv_en(d_adv), .ridx(d_ridx),
        .r_valid(d_valid), .r_cpu(d_cpu), .r_prio(d_prio), .r_addr(d_addr), .r_tgl(d_tgl)
    );

    evt_route_ctl #(.SRC_W(SRC_W), .DESC_W(DESC_W), .DATA_W(DATA_W), .CPU_W(CPU_W),
                    .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ntf_valid(ntf_valid), .ntf_src(ntf_src), .ntf_ready(ntf_ready),
        .asg_ridx(a_ridx), .asg_rmask(a_mask), .asg_rdesc(a_desc), .asg_rdata(a_data),
        .dsc_ridx(d_ridx), .adv_en(d_adv), .dsc_rvalid(d_valid), .dsc_rcpu(d_cpu),
        .dsc_rprio(d_prio), .dsc_raddr(d_addr), .dsc_rtgl(d_tgl),
        .qw_valid(qw_valid), .qw_addr(qw_addr), .qw_data(qw_data),
        .pr_valid(pr_valid), .pr_cpu(pr_cpu), .pr_prio(pr_prio), .err_cnt(err_cnt)
    );

    // R7: every queue write is followed by exactly one presenter notify
    p_notify_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        qw_valid |=> pr_valid);
    p_no_stray_notify_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !qw_valid |=> !pr_valid);

    // R8: an accepted notify holds off the next one
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && ntf_ready) |=> !ntf_ready);
endmodule

// File: tb/sim_evt_route_qwr.sv
module sim_evt_route_qwr;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ntf_valid = 1'b0;
    logic [3:0] ntf_src = '0;
    logic ntf_ready;
    logic asg_we = 1'b0, asg_mask = 1'b0;
    logic [3:0] asg_idx = '0;
    logic [2:0] asg_desc = '0;
    logic [15:0] asg_data = '0;
    logic dsc_we = 1'b0, dsc_valid = 1'b0;
    logic [2:0] dsc_idx = '0, dsc_cpu = '0, dsc_prio = '0, dsc_lg = '0;
    logic [15:0] dsc_base = '0;
    logic qw_valid, pr_valid;
    logic [15:0] qw_addr;
    logic [16:0] qw_data;
    logic [2:0] pr_cpu, pr_prio;
    logic [7:0] err_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int qw_n = 0;
    int pr_n = 0;
    logic [15:0] last_addr;
    logic [16:0] last_data;
    logic [2:0] last_cpu, last_prio;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_route_qwr u0 (
        .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_src(ntf_src), .ntf_ready(ntf_ready),
        .asg_we(asg_we), .asg_idx(asg_idx), .asg_mask(asg_mask), .asg_desc(asg_desc),
        .asg_data(asg_data), .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_valid(dsc_valid),
        .dsc_cpu(dsc_cpu), .dsc_prio(dsc_prio), .dsc_base(dsc_base), .dsc_lg(dsc_lg),
        .qw_valid(qw_valid), .qw_addr(qw_addr), .qw_data(qw_data), .pr_valid(pr_valid),
        .pr_cpu(pr_cpu), .pr_prio(pr_prio), .err_cnt(err_cnt)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (qw_valid) begin qw_n++; last_addr <= qw_addr; last_data <= qw_data; end
        if (pr_valid) begin pr_n++; last_cpu <= pr_cpu; last_prio <= pr_prio; end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_asg(input logic [3:0] s, input logic m, input logic [2:0] d, input logic [15:0] v);
        @(negedge clk);
        asg_we = 1'b1; asg_idx = s; asg_mask = m; asg_desc = d; asg_data = v;
        @(negedge clk);
        asg_we = 1'b0;
    endtask

    task automatic cfg_dsc(input logic [2:0] d, input logic v, input logic [2:0] c, input logic [2:0] p,
                           input logic [15:0] b, input logic [2:0] lg);
        @(negedge clk);
        dsc_we = 1'b1; dsc_idx = d; dsc_valid = v; dsc_cpu = c; dsc_prio = p; dsc_base = b; dsc_lg = lg;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    task automatic send(input logic [3:0] s);
        @(negedge clk);
        while (!ntf_ready) @(negedge clk);
        ntf_valid = 1'b1; ntf_src = s;
        @(negedge clk);
        ntf_valid = 1'b0;
    endtask

    // Vector: {src[4], wr[1], err[1], cpu[3], prio[3], addr[16], data[17]}
    localparam logic [44:0] VEC [NV] = '{
        {4'd0, 1'b1, 1'b0, 3'd2, 3'd5, 16'h0100, 17'h11111},
        {4'd1, 1'b1, 1'b0, 3'd6, 3'd1, 16'h0200, 17'h12222},
        {4'd2, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 17'h00000},
        {4'd4, 1'b1, 1'b0, 3'd2, 3'd5, 16'h0101, 17'h15555},
        {4'd1, 1'b1, 1'b0, 3'd6, 3'd1, 16'h0201, 17'h12222},
        {4'd0, 1'b1, 1'b0, 3'd2, 3'd5, 16'h0102, 17'h11111},
        {4'd3, 1'b0, 1'b1, 3'd0, 3'd0, 16'h0000, 17'h00000},
        {4'd0, 1'b1, 1'b0, 3'd2, 3'd5, 16'h0103, 17'h11111},
        {4'd1, 1'b1, 1'b0, 3'd6, 3'd1, 16'h0200, 17'h02222},
        {4'd4, 1'b1, 1'b0, 3'd2, 3'd5, 16'h0100, 17'h05555},
        {4'd2, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 17'h00000}
    };

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int qn0, pn0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ntf_ready === 1'b1, "R1 ready", 64'(ntf_ready), 64'd1);
        chk(qw_valid === 1'b0 && pr_valid === 1'b0, "R1 strobes", {qw_valid, pr_valid}, 64'd0);
        chk(err_cnt === 8'd0, "R1 err_cnt", 64'(err_cnt), 64'd0);
        // R1: sources start masked, so nothing is written and no error counts
        send(4'd5);
        repeat (4) @(negedge clk);
        chk(qw_n == 0 && pr_n == 0 && err_cnt == 0, "R1 masked at reset",
            64'(qw_n + pr_n + int'(err_cnt)), 64'd0);

        // Table setup: D0 cpu2 prio5 base 0x100 4 entries; D1 cpu6 prio1 base 0x200 2 entries; D2 invalid
        cfg_dsc(3'd0, 1'b1, 3'd2, 3'd5, 16'h0100, 3'd2);
        cfg_dsc(3'd1, 1'b1, 3'd6, 3'd1, 16'h0200, 3'd1);
        cfg_dsc(3'd2, 1'b0, 3'd0, 3'd0, 16'h0300, 3'd0);
        cfg_asg(4'd0, 1'b0, 3'd0, 16'h1111);
        cfg_asg(4'd1, 1'b0, 3'd1, 16'h2222);
        cfg_asg(4'd2, 1'b1, 3'd0, 16'h3333);
        cfg_asg(4'd3, 1'b0, 3'd2, 16'h4444);
        cfg_asg(4'd4, 1'b0, 3'd0, 16'h5555);

        // Vector walk: R2, R3, R4, R5, R9, R10 with interleaved queues and wraps
        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            qn0 = qw_n; pn0 = pr_n; e0 = int'(err_cnt);
            send(v[44:41]);
            repeat (4) @(negedge clk);
            if (v[40]) begin
                chk(qw_n == qn0 + 1 && pr_n == pn0 + 1, "R3/R4/R5/R10 write count",
                    64'(qw_n - qn0), 64'd1);
                chk(last_addr === v[32:17], "R4/R5/R10 addr", 64'(last_addr), 64'(v[32:17]));
                chk(last_data === v[16:0], "R3/R5 data", 64'(last_data), 64'(v[16:0]));
                chk(last_cpu === v[38:36] && last_prio === v[35:33], "R7 cpu/prio",
                    {last_cpu, last_prio}, {v[38:36], v[35:33]});
            end else if (v[39]) begin
                chk(qw_n == qn0 && pr_n == pn0 && int'(err_cnt) == e0 + 1, "R9 invalid discard",
                    64'(err_cnt), 64'(e0 + 1));
            end else begin
                chk(qw_n == qn0 && pr_n == pn0 && int'(err_cnt) == e0, "R2 masked drop",
                    64'(qw_n - qn0), 64'd0);
            end
        end
        // State now: D0 index 1 toggle 0, D1 index 1 toggle 0

        // R8/R7: cycle timing of one notify (S0 -> 0x101, toggle 0)
        @(negedge clk);
        ntf_valid = 1'b1; ntf_src = 4'd0;
        @(negedge clk);
        ntf_valid = 1'b0;
        chk(ntf_ready === 1'b0 && qw_valid === 1'b0, "R8 edge+0", {ntf_ready, qw_valid}, 64'd0);
        @(negedge clk);
        chk(ntf_ready === 1'b0 && qw_valid === 1'b0, "R8 edge+1", {ntf_ready, qw_valid}, 64'd0);
        @(negedge clk);
        chk(qw_valid === 1'b1 && ntf_ready === 1'b1 && qw_addr === 16'h0101 && qw_data === 17'h01111,
            "R8 edge+2 write", {qw_valid, ntf_ready, qw_addr, qw_data}, {2'b11, 16'h0101, 17'h01111});
        chk(pr_valid === 1'b0, "R7 no early notify", 64'(pr_valid), 64'd0);
        @(negedge clk);
        chk(pr_valid === 1'b1 && pr_cpu === 3'd2 && pr_prio === 3'd5 && qw_valid === 1'b0,
            "R7 notify edge+3", {pr_valid, pr_cpu, pr_prio, qw_valid}, {1'b1, 3'd2, 3'd5, 1'b0});
        @(negedge clk);
        chk(pr_valid === 1'b0, "R7 single notify", 64'(pr_valid), 64'd0);

        // R8: a notify held during backpressure is not lost (S0 then S4)
        qn0 = qw_n;
        @(negedge clk);
        ntf_valid = 1'b1; ntf_src = 4'd0;
        @(negedge clk);
        ntf_src = 4'd4;
        do @(negedge clk); while (!ntf_ready);
        @(negedge clk);
        ntf_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(qw_n == qn0 + 2, "R8 backpressure count", 64'(qw_n - qn0), 64'd2);
        chk(last_addr === 16'h0103 && last_data === 17'h05555, "R8 held notify served",
            {last_addr, last_data}, {16'h0103, 17'h05555});

        // R6: reconfiguring D1 restarts it at slot 0 with toggle 1
        cfg_dsc(3'd1, 1'b1, 3'd6, 3'd1, 16'h0200, 3'd1);
        send(4'd1);
        repeat (4) @(negedge clk);
        chk(last_addr === 16'h0200 && last_data === 17'h12222, "R6 restart",
            {last_addr, last_data}, {16'h0200, 17'h12222});

        // R9: error counter saturates
        for (int k = 0; k < 300; k++) send(4'd3);
        repeat (4) @(negedge clk);
        chk(err_cnt === 8'hFF, "R9 saturation", 64'(err_cnt), 64'hFF);

        summary();
        $finish;
    end
endmodule